// File: doc/BRIEF.md
# Dual-Channel Auxiliary Reading Smoother and Threshold Monitor

This block sits after two auxiliary converter channels and turns their raw 10-bit sample streams into steadier readings that a host can watch. Each channel can be switched off through a source-select field. When it is on, each channel can smooth its readings with a shift-based exponential average whose strength is set by a coefficient exponent. The smoothed reading is then compared against a high and a low threshold that are set apart to give hysteresis. Crossing the high threshold on the way up, or the low threshold on the way down, sets a sticky event flag. Flags can be masked onto a single interrupt line.

A global bias-enable input gates all processing. The host programs each channel through a narrow write port that selects a channel and a register. It clears all event flags with a one-cycle clear strobe. Each channel is run by a four-state controller. IDLE means the channel is inactive. PRIME means the channel is active and waiting for its first sample. BELOW and ABOVE are the two tracking states. The transitions are:
- IDLE to PRIME when the channel becomes active with no sample present.
- IDLE or PRIME to BELOW or ABOVE on the first accepted sample, which loads the average directly.
- BELOW to ABOVE on a high crossing.
- ABOVE to BELOW on a low crossing.
- Any state to IDLE when the channel goes inactive.

Top module: `auxmon_top`

## Requirements
- R1: There are two channels with separate configuration. A channel is active only while its source field (control bits [2:0]) is non-zero and bias_en is high. An inactive channel accepts no samples, and its reading holds its last value.
- R2: While bias_en is low, no channel accepts samples. Readings hold and no event flag is set.
- R3: When averaging is enabled, each accepted sample s updates the internal average as avg += ((s·2^10) − avg) >>> (N+1), using an arithmetic shift. The average keeps 10 fraction bits. The reading avg_out is the integer part of the average. N is control bits [7:4].
- R4: The coefficient N resets to 0. A written value above 9 is stored as 9.
- R5: Control bit [3] enables averaging and resets to 0. While it is 0, the reading equals the latest accepted sample.
- R6: The first accepted sample after a channel becomes active loads the average directly, without filtering.
- R7: Each reading is compared after averaging. In BELOW or PRIME, a reading greater than the high threshold sets the high flag flags[2c] and moves the channel to ABOVE. In ABOVE, a reading less than the low threshold sets the low flag flags[2c+1] and moves the channel to BELOW.
- R8: Hysteresis: a channel in ABOVE raises no further high event, and a reading between the two thresholds causes no event. The two flags of a channel are never newly set in the same cycle.
- R9: Flags are sticky until stat_clr, which clears all flags. An event in the same cycle as stat_clr leaves its flag set.
- R10: irq is high exactly when some flag is set whose enable bit is set. The high-event enable is control bit [8] and the low-event enable is control bit [9]. Both reset to 0.
- R11: After reset, all readings are 0, all flags are 0, irq is 0, every source field is 0, each high threshold is 1023 and each low threshold is 0.
- R12: A write with cfg_we high goes to channel cfg_ch. cfg_reg selects the target: 0 is control, 1 is the high threshold and 2 is the low threshold, each taking cfg_wdata[9:0]. A write with cfg_reg = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bias_en | input | 1 | Global enable for all sample processing |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel selected for the write |
| cfg_reg | input | 2 | Register selected: 0 control, 1 high threshold, 2 low threshold |
| cfg_wdata | input | 10 | Write data |
| smp_vld | input | 2 | Sample-valid strobe, one bit per channel |
| smp_data | input | 20 | Raw samples, channel c in bits [10c+9:10c] |
| stat_clr | input | 1 | Clears all event flags |
| avg_out | output | 20 | Integer reading, channel c in bits [10c+9:10c] |
| flags | output | 4 | Sticky events: bit 2c is high crossing, bit 2c+1 is low crossing |
| irq | output | 1 | OR of all set and enabled flags |

## Verification
The clamp of the averaging exponent is the hardest behaviour to see from the ports. The coefficient cannot be read back, and a coefficient of 9 and a larger one look the same for the first few samples. The stimulus therefore re-primes a channel at zero with a coefficient of 15 written, then feeds a long run of full-scale samples. After that run, only a clamped shift has let the integer reading climb well above zero. A second hard case is an event arriving in the same cycle as the clear strobe. The bench forces this by pulsing stat_clr together with a sample that crosses the high threshold.

// File: rtl/auxmon_pkg.sv
package auxmon_pkg;
    parameter int SMP_W    = 10;
    parameter int SRC_W    = 3;
    parameter int COEF_W   = 4;
    parameter int COEF_MAX = 9;
    parameter int CFG_W    = 10;

    localparam int CTL_SRC_LSB  = 0;
    localparam int CTL_AVG_BIT  = 3;
    localparam int CTL_COEF_LSB = 4;
    localparam int CTL_HIEN_BIT = 8;
    localparam int CTL_LOEN_BIT = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_BELOW = 2'd2,
        ST_ABOVE = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_THR_HI = 2'd1,
        REG_THR_LO = 2'd2,
        REG_SPARE  = 2'd3
    } cfg_reg_e;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic              avg_en;
        logic [COEF_W-1:0] coef;
        logic              irq_hi_en;
        logic              irq_lo_en;
        logic [SMP_W-1:0]  thr_hi;
        logic [SMP_W-1:0]  thr_lo;
    } ch_cfg_t;

    function automatic logic [COEF_W-1:0] clamp_coef(input logic [COEF_W-1:0] v);
        if (v > COEF_W'(COEF_MAX))
            return COEF_W'(COEF_MAX);
        return v;
    endfunction
endpackage

// File: rtl/auxmon_cfg.sv
module auxmon_cfg
    import auxmon_pkg::*;
#(
    parameter int CH  = 2,
    parameter int CHW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CHW-1:0]   ch_i,
    input  logic [1:0]       reg_i,
    input  logic [CFG_W-1:0] wdata_i,
    output ch_cfg_t          cfg_o [CH]
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        ch_cfg_t cfg_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q.src       <= '0;
                cfg_q.avg_en    <= 1'b0;
                cfg_q.coef      <= '0;
                cfg_q.irq_hi_en <= 1'b0;
                cfg_q.irq_lo_en <= 1'b0;
                cfg_q.thr_hi    <= '1;
                cfg_q.thr_lo    <= '0;
            end else if (we_i && (ch_i == CHW'(c))) begin
                case (reg_i)
                    REG_CTRL: begin
                        cfg_q.src       <= wdata_i[CTL_SRC_LSB +: SRC_W];
                        cfg_q.avg_en    <= wdata_i[CTL_AVG_BIT];
                        cfg_q.coef      <= clamp_coef(wdata_i[CTL_COEF_LSB +: COEF_W]);
                        cfg_q.irq_hi_en <= wdata_i[CTL_HIEN_BIT];
                        cfg_q.irq_lo_en <= wdata_i[CTL_LOEN_BIT];
                    end
                    REG_THR_HI: cfg_q.thr_hi <= wdata_i[SMP_W-1:0];
                    REG_THR_LO: cfg_q.thr_lo <= wdata_i[SMP_W-1:0];
                    default: ;
                endcase
            end
        end
        assign cfg_o[c] = cfg_q;
    end
endmodule

// File: rtl/auxmon_filter.sv
module auxmon_filter
    import auxmon_pkg::*;
#(
    parameter int FW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              first_i,
    input  logic              avg_en_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic [SMP_W-1:0]  sample_i,
    output logic [SMP_W-1:0]  rd_next_o,
    output logic [SMP_W-1:0]  rd_o
);
    localparam int AW = SMP_W + FW;

    logic [AW-1:0]       acc_q, acc_d, target;
    logic signed [AW:0]  diff, step;
    logic [COEF_W:0]     shamt;

    always_comb begin
        target = {sample_i, {FW{1'b0}}};
        shamt  = (COEF_W+1)'(coef_i) + (COEF_W+1)'(1);
        diff   = $signed({1'b0, target}) - $signed({1'b0, acc_q});
        step   = diff >>> shamt;
        if (first_i || !avg_en_i)
            acc_d = target;
        else
            acc_d = AW'({1'b0, acc_q} + $unsigned(step));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (accept_i)
            acc_q <= acc_d;
    end

    assign rd_next_o = acc_d[AW-1:FW];
    assign rd_o      = acc_q[AW-1:FW];
endmodule

// File: rtl/auxmon_ctrl.sv
module auxmon_ctrl
    import auxmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] rd_next_i,
    input  logic [SMP_W-1:0] thr_hi_i,
    input  logic [SMP_W-1:0] thr_lo_i,
    output logic             accept_o,
    output logic             first_o,
    output logic             ev_hi_o,
    output logic             ev_lo_o
);
    ch_state_e st_q, st_d;

    assign first_o = (st_q == ST_IDLE) || (st_q == ST_PRIME);

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        accept_o = active_i && vld_i;
        ev_hi_o  = 1'b0;
        ev_lo_o  = 1'b0;
        if (!active_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_PRIME: begin
                    if (vld_i) begin
                        if (rd_next_i > thr_hi_i) begin
                            st_d    = ST_ABOVE;
                            ev_hi_o = 1'b1;
                        end else begin
                            st_d = ST_BELOW;
                        end
                    end else begin
                        st_d = ST_PRIME;
                    end
                end
                ST_BELOW: begin
                    if (vld_i && (rd_next_i > thr_hi_i)) begin
                        st_d    = ST_ABOVE;
                        ev_hi_o = 1'b1;
                    end
                end
                ST_ABOVE: begin
                    if (vld_i && (rd_next_i < thr_lo_i)) begin
                        st_d    = ST_BELOW;
                        ev_lo_o = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/auxmon_flags.sv
module auxmon_flags #(
    parameter int CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [CH-1:0]   ev_hi_i,
    input  logic [CH-1:0]   ev_lo_i,
    input  logic [2*CH-1:0] mask_i,
    output logic [2*CH-1:0] flags_o,
    output logic            irq_o
);
    logic [2*CH-1:0] flg_q, ev_vec;

    for (genvar c = 0; c < CH; c++) begin : g_ev
        assign ev_vec[2*c]   = ev_hi_i[c];
        assign ev_vec[2*c+1] = ev_lo_i[c];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flg_q <= '0;
        else if (clr_i)
            flg_q <= ev_vec;
        else
            flg_q <= flg_q | ev_vec;
    end

    assign flags_o = flg_q;
    assign irq_o   = |(flg_q & mask_i);
endmodule

// File: rtl/auxmon_top.sv
module auxmon_top
    import auxmon_pkg::*;
#(
    parameter int CH  = 2,
    parameter int FW  = 10,
    parameter int CHW = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bias_en,
    input  logic                cfg_we,
    input  logic [CHW-1:0]      cfg_ch,
    input  logic [1:0]          cfg_reg,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [CH-1:0]       smp_vld,
    input  logic [CH*SMP_W-1:0] smp_data,
    input  logic                stat_clr,
    output logic [CH*SMP_W-1:0] avg_out,
    output logic [2*CH-1:0]     flags,
    output logic                irq
);
    ch_cfg_t             cfg [CH];
    logic [CH-1:0]       src_on, ev_hi, ev_lo;
    logic [2*CH-1:0]     mask_vec;
    logic [CH*SMP_W-1:0] hi_flat, lo_flat;

    auxmon_cfg #(.CH(CH), .CHW(CHW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .ch_i(cfg_ch),
        .reg_i(cfg_reg), .wdata_i(cfg_wdata), .cfg_o(cfg)
    );

    for (genvar c = 0; c < CH; c++) begin : g_chan
        logic             accept, first;
        logic [SMP_W-1:0] rd_next, rd;

        assign src_on[c]             = bias_en && (cfg[c].src != '0);
        assign mask_vec[2*c]         = cfg[c].irq_hi_en;
        assign mask_vec[2*c+1]       = cfg[c].irq_lo_en;
        assign hi_flat[c*SMP_W +: SMP_W] = cfg[c].thr_hi;
        assign lo_flat[c*SMP_W +: SMP_W] = cfg[c].thr_lo;

        auxmon_filter #(.FW(FW)) u_filt (
            .clk(clk), .rst_n(rst_n), .accept_i(accept), .first_i(first),
            .avg_en_i(cfg[c].avg_en), .coef_i(cfg[c].coef),
            .sample_i(smp_data[c*SMP_W +: SMP_W]),
            .rd_next_o(rd_next), .rd_o(rd)
        );

        auxmon_ctrl u_ctrl (
            .clk(clk), .rst_n(rst_n), .active_i(src_on[c]), .vld_i(smp_vld[c]),
            .rd_next_i(rd_next), .thr_hi_i(cfg[c].thr_hi), .thr_lo_i(cfg[c].thr_lo),
            .accept_o(accept), .first_o(first), .ev_hi_o(ev_hi[c]), .ev_lo_o(ev_lo[c])
        );

        assign avg_out[c*SMP_W +: SMP_W] = rd;
    end

    auxmon_flags #(.CH(CH)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr_i(stat_clr), .ev_hi_i(ev_hi),
        .ev_lo_i(ev_lo), .mask_i(mask_vec), .flags_o(flags), .irq_o(irq)
    );
endmodule

// File: rtl/auxmon_chk.sv
module auxmon_chk
    import auxmon_pkg::*;
#(
    parameter int CH = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bias_en,
    input logic                stat_clr,
    input logic [CH-1:0]       src_on,
    input logic [2*CH-1:0]     mask_vec,
    input logic [CH*SMP_W-1:0] hi_flat,
    input logic [CH*SMP_W-1:0] lo_flat,
    input logic [CH*SMP_W-1:0] avg_out,
    input logic [2*CH-1:0]     flags,
    input logic                irq
);
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & mask_vec) == '0) |-> !irq);

    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((flags & $past(flags)) == $past(flags)));

    assert_bias_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_en |=> ($stable(avg_out) && ((flags & ~$past(flags)) == '0)));

    for (genvar c = 0; c < CH; c++) begin : g_chk
        assert_off_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !src_on[c] |=> $stable(avg_out[c*SMP_W +: SMP_W]));

        assert_hi_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[2*c] && !$past(flags[2*c]))
            |-> (avg_out[c*SMP_W +: SMP_W] > $past(hi_flat[c*SMP_W +: SMP_W])));

        assert_lo_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[2*c+1] && !$past(flags[2*c+1]))
            |-> (avg_out[c*SMP_W +: SMP_W] < $past(lo_flat[c*SMP_W +: SMP_W])));

        assert_no_dual_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(flags[2*c] && !$past(flags[2*c]) && flags[2*c+1] && !$past(flags[2*c+1])));
    end
endmodule

bind auxmon_top auxmon_chk #(.CH(CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bias_en(bias_en), .stat_clr(stat_clr),
    .src_on(src_on), .mask_vec(mask_vec), .hi_flat(hi_flat), .lo_flat(lo_flat),
    .avg_out(avg_out), .flags(flags), .irq(irq)
);

// File: tb/sim_auxmon_top.sv
`timescale 1ns/1ps
module sim_auxmon_top;
    localparam int FRAC = 10;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bias_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [1:0]  cfg_reg = '0;
    logic [9:0]  cfg_wdata = '0;
    logic [1:0]  smp_vld = '0;
    logic [19:0] smp_data = '0;
    logic        stat_clr = 1'b0;
    logic [19:0] avg_out;
    logic [3:0]  flags;
    logic        irq;

    int nchk = 0, nfail = 0, ncyc = 0;

    always #2.5 clk = ~clk;

    auxmon_top u0 (
        .clk(clk), .rst_n(rst_n), .bias_en(bias_en), .cfg_we(cfg_we),
        .cfg_ch(cfg_ch), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .smp_vld(smp_vld), .smp_data(smp_data), .stat_clr(stat_clr),
        .avg_out(avg_out), .flags(flags), .irq(irq)
    );

    // behavioural reference model
    int m_acc[2], m_src[2], m_coef[2], m_hi[2], m_lo[2];
    bit m_prim[2], m_above[2], m_avg[2], m_eh[2], m_el[2];
    bit [3:0] m_flags, m_ev;
    int tgt, dlt, rdv, cw;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_acc[c] = 0; m_prim[c] = 0; m_above[c] = 0; m_src[c] = 0;
                m_avg[c] = 0; m_coef[c] = 0; m_eh[c] = 0; m_el[c] = 0;
                m_hi[c] = 1023; m_lo[c] = 0;
            end
            m_flags = '0;
        end else begin
            m_ev = '0;
            for (int c = 0; c < 2; c++) begin
                if (!(bias_en && m_src[c] != 0)) begin
                    m_prim[c] = 0; m_above[c] = 0;
                end else if (smp_vld[c]) begin
                    tgt = int'(smp_data[c*10 +: 10]) * 1024;
                    if (!m_prim[c] || !m_avg[c]) m_acc[c] = tgt;
                    else begin
                        dlt = tgt - m_acc[c];
                        m_acc[c] = m_acc[c] + (dlt >>> (m_coef[c] + 1));
                    end
                    m_prim[c] = 1;
                    rdv = m_acc[c] >> FRAC;
                    if (!m_above[c] && rdv > m_hi[c]) begin
                        m_above[c] = 1; m_ev[2*c] = 1'b1;
                    end else if (m_above[c] && rdv < m_lo[c]) begin
                        m_above[c] = 0; m_ev[2*c+1] = 1'b1;
                    end
                end
            end
            if (stat_clr) m_flags = '0;
            m_flags = m_flags | m_ev;
            if (cfg_we) begin
                if (cfg_reg == 2'd0) begin
                    m_src[cfg_ch]  = int'(cfg_wdata[2:0]);
                    m_avg[cfg_ch]  = cfg_wdata[3];
                    cw = int'(cfg_wdata[7:4]);
                    m_coef[cfg_ch] = (cw > 9) ? 9 : cw;
                    m_eh[cfg_ch]   = cfg_wdata[8];
                    m_el[cfg_ch]   = cfg_wdata[9];
                end else if (cfg_reg == 2'd1) m_hi[cfg_ch] = int'(cfg_wdata);
                else if (cfg_reg == 2'd2) m_lo[cfg_ch] = int'(cfg_wdata);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // lockstep comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 reading ch0", int'(avg_out[9:0]), m_acc[0] >> FRAC);
            check("R3 reading ch1", int'(avg_out[19:10]), m_acc[1] >> FRAC);
            check("R7 flags", int'(flags), int'(m_flags));
            check("R10 irq", int'(irq),
                  int'(|(m_flags & {m_el[1], m_eh[1], m_el[0], m_eh[0]})));
        end
    end

    always @(posedge clk) begin
        ncyc++;
        if (ncyc == WD_LIMIT) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", ncyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int ch, input int rg, input int data);
        cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_reg = 2'(rg); cfg_wdata = 10'(data);
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic smp(input int ch, input int val);
        smp_vld[ch] = 1'b1;
        smp_data[ch*10 +: 10] = 10'(val);
        cyc();
        smp_vld = '0;
    endtask

    task automatic clr();
        stat_clr = 1'b1;
        cyc();
        stat_clr = 1'b0;
    endtask

    int hold0, hold1;

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R11 reset readings", int'(avg_out), 0);
        check("R11 reset flags", int'(flags), 0);
        check("R11 reset irq", int'(irq), 0);

        // channel 0 on, averaging off
        wr(0, 0, 10'h001);
        smp(0, 1023);
        check("R5 raw reading", int'(avg_out[9:0]), 1023);
        check("R11 default thresholds give no event", int'(flags), 0);
        smp(1, 500);
        check("R1 off channel ignores sample", int'(avg_out[19:10]), 0);
        smp(0, 300);
        check("R5 latest sample", int'(avg_out[9:0]), 300);

        // averaging on, coefficient 2
        wr(0, 0, 10'h029);
        smp(0, 100);
        check("R3 average coef 2", int'(avg_out[9:0]), 275);

        // re-prime
        wr(0, 0, 10'h028);
        cyc();
        wr(0, 0, 10'h029);
        smp(0, 800);
        check("R6 first sample loads", int'(avg_out[9:0]), 800);
        smp(0, 0);
        check("R3 average step", int'(avg_out[9:0]), 700);

        // coefficient 15 must act as 9
        wr(0, 0, 10'h0F8);
        cyc();
        wr(0, 0, 10'h0F9);
        smp(0, 0);
        for (int i = 0; i < 100; i++) smp(0, 1023);
        check("R4 clamped coef lets reading rise", int'(avg_out[9:0] > 10'd50), 1);

        // thresholds on channel 1
        wr(1, 1, 600);
        wr(1, 2, 200);
        wr(1, 0, 10'h302);
        clr();
        smp(1, 100);
        check("R7 below high no event", int'(flags[3:2]), 0);
        smp(1, 700);
        check("R7 high crossing flag", int'(flags[2]), 1);
        check("R10 irq enabled high", int'(irq), 1);
        clr();
        check("R9 clear flags", int'(flags), 0);
        check("R9 clear irq", int'(irq), 0);
        smp(1, 800);
        check("R8 no repeat while above", int'(flags[2]), 0);
        smp(1, 400);
        check("R8 between thresholds no event", int'(flags[3:2]), 0);
        smp(1, 150);
        check("R7 low crossing flag", int'(flags[3]), 1);

        // masking
        clr();
        wr(1, 0, 10'h102);
        smp(1, 700);
        check("R10 high enabled irq", int'(irq), 1);
        clr();
        smp(1, 100);
        check("R10 low flag set", int'(flags[3]), 1);
        check("R10 low masked irq", int'(irq), 0);

        // event during clear
        stat_clr = 1'b1;
        smp_vld[1] = 1'b1; smp_data[19:10] = 10'd700;
        cyc();
        stat_clr = 1'b0; smp_vld = '0;
        check("R9 set wins over clear", int'(flags), 4'b0100);
        clr();

        // spare register write ignored
        wr(1, 3, 0);
        smp(1, 100);
        check("R12 spare write ignored reading", int'(avg_out[19:10]), 100);
        check("R12 spare write ignored event", int'(flags[3]), 1);
        clr();

        // bias off
        hold0 = int'(avg_out[9:0]); hold1 = int'(avg_out[19:10]);
        bias_en = 1'b0;
        smp(0, 500);
        smp(1, 900);
        check("R2 bias off ch0 holds", int'(avg_out[9:0]), hold0);
        check("R2 bias off ch1 holds", int'(avg_out[19:10]), hold1);
        check("R2 bias off no events", int'(flags), 0);
        bias_en = 1'b1;

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            smp_vld  = 2'($urandom);
            smp_data = 20'($urandom);
            stat_clr = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 60) == 0) bias_en = ~bias_en;
            if ($urandom_range(0, 20) == 0) begin
                cfg_we = 1'b1; cfg_ch = 1'($urandom);
                cfg_reg = 2'($urandom); cfg_wdata = 10'($urandom);
            end else cfg_we = 1'b0;
            cyc();
        end
        smp_vld = '0; stat_clr = 1'b0; cfg_we = 1'b0;
        cyc();

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule